// File: doc/BRIEF.md
# SD Data Lane Agent

This block is the data-line engine of an SD/MMC host. It moves block data between a byte-wide buffer stream and the card's data lines, one bit per lane per SD clock, over a bus of 1, 4 or 8 lanes. Each lane carries its own 16-bit check value. On writes the block frames the data and appends the per-lane check and end bits. It then skips the card's write-status token and reports card busy while lane 0 is held low. On reads it waits for a start bit, rebuilds bytes and checks every active lane's check value against a sticky error flag. Between blocks it can hold lane 2 low to request read-wait.

The block runs on the SD clock. It drives lanes on its rising edge and samples the lanes on its rising edge. Lane drive is open-drain style: an output enable per lane, and a value that reads as one on every lane that is not driven. The lane width and block length are latched when a transfer starts. The buffer side must offer a byte whenever `wr_ready` is high during a write.

Top module: `sd_dat_agent`

## Requirements
- R1: After reset no lane is driven (`dat_oe` = 0, `dat_out` = 8'hFF), and `card_busy`, `rd_valid`, `crc_err` and `wr_ready` are all low. Outside a block, lanes stay released unless read-wait is active.
- R2: `lane_sel` encoding: 2'b00 selects lane 0 only, 2'b01 selects lanes 0–3, 2'b10 selects lanes 0–7, and 2'b11 behaves as 2'b00. Only selected lanes are driven during a write block.
- R3: A write starts in the cycle after `wr_start` is sampled in idle. The block drives a start bit of 0 on all selected lanes, then the data, then 16 check bits, then one end bit of 1. It then releases the lanes.
- R4: Data lane mapping. In 1-lane mode each byte goes out MSB first on lane 0 over 8 clocks. In 4-lane mode bits [7:4] go out on the first clock and bits [3:0] on the second, with bit 7 and bit 3 on lane 3 and bit 4 and bit 0 on lane 0. In 8-lane mode one byte goes out per clock, with bit k on lane k.
- R5: Each lane's check value is the remainder of its bit stream times x^16 divided by x^16 + x^12 + x^5 + 1. The first bit on the lane is the highest-order term. The value is cleared to zero at the start of every block and sent MSB first.
- R6: A write block takes exactly `blk_len` bytes from the buffer stream, one per cycle in which `wr_ready` and `wr_valid` are both high.
- R7: After `rd_start`, the block waits for lane 0 to be sampled low and then deserializes with the R4 mapping. `rd_valid` pulses with the byte in the cycle after the byte's last bit clock is sampled.
- R8: After the 16 check bits and the end bit of a read, `crc_err` is set if any selected lane's received check value is wrong. Unselected lanes are ignored. The flag stays set until `err_clr` is sampled high.
- R9: After a write's end bit, the block watches lane 0. It skips the status token: a low start bit, three status bits and an end bit. `card_busy` is high from the cycle after the token's end bit is sampled until the cycle after lane 0 is sampled high.
- R10: In idle with `rw_en` and `rw_req` both high, lane 2 is driven low from the next cycle onward. Lane 2 is not driven when `rw_en` is low or while a block or busy phase is running.
- R11: `wr_start` and `rd_start` have no effect while a transfer or busy phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_sel | input | 2 | Lane width select (R2) |
| blk_len | input | BLEN_W | Bytes per block, at least 1 |
| wr_start | input | 1 | Begin a write block |
| rd_start | input | 1 | Begin a read block |
| wr_data | input | 8 | Byte from the buffer |
| wr_valid | input | 1 | Buffer byte available |
| wr_ready | output | 1 | Block takes the byte this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte strobe |
| dat_in | input | 8 | Sampled data lanes |
| dat_out | output | 8 | Driven lane values |
| dat_oe | output | 8 | Per-lane drive enable |
| card_busy | output | 1 | Card is busy after a write |
| crc_err | output | 1 | Sticky read check error |
| err_clr | input | 1 | Clears `crc_err` |
| rw_en | input | 1 | Read-wait permitted |
| rw_req | input | 1 | Buffer side asks for read-wait |

## Verification
Writes are run in every lane width, including the 2'b11 alias, with distinct byte patterns. A wrong lane order or nibble order shows up at once in the per-clock comparison, and any mistake in the check bits shows up in the 16 trailing clocks. Reads are run clean, with a single check bit flipped on a selected lane, and with noise on unselected lanes. Together these separate a correct check from one that ignores lanes, and from one that reads lanes it should mask. Busy phases of zero and several cycles test where the busy window starts and ends. Read-wait is tried enabled, disabled and mid-block, and start pulses are injected mid-transfer to show they are ignored.

// File: rtl/sd_dat_agent.sv
module sd_dat_agent #(
  parameter int BLEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lane_sel,
  input  logic [BLEN_W-1:0] blk_len,
  input  logic              wr_start,
  input  logic              rd_start,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic [7:0]        dat_in,
  output logic [7:0]        dat_out,
  output logic [7:0]        dat_oe,
  output logic              card_busy,
  output logic              crc_err,
  input  logic              err_clr,
  input  logic              rw_en,
  input  logic              rw_req
);
  localparam int NL = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_TX_SB, S_TX_DAT, S_TX_CRC, S_TX_EB, S_TOK, S_BUSY,
    S_RX_WAIT, S_RX_DAT, S_RX_CRC, S_RX_EB
  } st_t;

  st_t st;
  logic [1:0]        wq;
  logic [7:0]        sh;
  logic [2:0]        ph;
  logic [3:0]        cnt;
  logic [BLEN_W-1:0] bcnt, blen_q;
  logic              rw_drv;
  logic [NL-1:0]     crc_msb, crc_nz, txb, act;
  logic [7:0]        rx_next;
  logic              last_ph, last_byte;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return {c[14:0], 1'b0} ^ (((c[15] ^ b) != 1'b0) ? 16'h1021 : 16'h0000);
  endfunction

  wire [1:0] wsel = (lane_sel == 2'b11) ? 2'b00 : lane_sel;

  assign act       = (wq == 2'd2) ? 8'hFF : (wq == 2'd1) ? 8'h0F : 8'h01;
  assign last_ph   = ph == ((wq == 2'd2) ? 3'd0 : (wq == 2'd1) ? 3'd1 : 3'd7);
  assign last_byte = bcnt == BLEN_W'(blen_q - 1'b1);
  assign txb       = (wq == 2'd2) ? sh : (wq == 2'd1) ? {4'hF, sh[7:4]} : {7'h7F, sh[7]};
  assign rx_next   = (wq == 2'd2) ? dat_in
                   : (wq == 2'd1) ? {sh[3:0], dat_in[3:0]} : {sh[6:0], dat_in[0]};

  generate
    for (genvar k = 0; k < NL; k++) begin : g_lane
      logic [15:0] c;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                              c <= '0;
        else if (st == S_IDLE)                   c <= '0;
        else if (st == S_TX_DAT)                 c <= crc_step(c, txb[k]);
        else if (st == S_TX_CRC)                 c <= {c[14:0], 1'b0};
        else if (st == S_RX_DAT || st == S_RX_CRC) c <= crc_step(c, dat_in[k]);
      assign crc_msb[k] = c[15];
      assign crc_nz[k]  = |c;
    end
  endgenerate

  always_comb begin
    dat_oe  = 8'h00;
    dat_out = 8'hFF;
    case (st)
      S_TX_SB:  begin dat_oe = act; dat_out = ~act; end
      S_TX_DAT: begin dat_oe = act; dat_out = txb | ~act; end
      S_TX_CRC: begin dat_oe = act; dat_out = crc_msb | ~act; end
      S_TX_EB:  dat_oe = act;
      S_IDLE:   if (rw_drv) begin dat_oe = 8'h04; dat_out = 8'hFB; end
      default:  ;
    endcase
  end

  assign wr_ready  = (st == S_TX_SB) || (st == S_TX_DAT && last_ph && !last_byte);
  assign card_busy = st == S_BUSY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wq <= 2'd0; sh <= 8'h00; ph <= 3'd0; cnt <= 4'd0;
      bcnt <= '0; blen_q <= '0; rw_drv <= 1'b0;
      rd_valid <= 1'b0; rd_data <= 8'h00; crc_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rw_drv   <= (st == S_IDLE) && !wr_start && !rd_start && rw_en && rw_req;
      if (err_clr) crc_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (wr_start) begin
            st <= S_TX_SB; wq <= wsel; blen_q <= blk_len;
          end else if (rd_start) begin
            st <= S_RX_WAIT; wq <= wsel; blen_q <= blk_len;
          end
        end
        S_TX_SB: if (wr_valid) begin
          sh <= wr_data; ph <= 3'd0; bcnt <= '0; st <= S_TX_DAT;
        end
        S_TX_DAT: begin
          if (last_ph) begin
            if (last_byte) begin
              st <= S_TX_CRC; cnt <= 4'd0;
            end else begin
              sh <= wr_data; ph <= 3'd0; bcnt <= bcnt + 1'b1;
            end
          end else begin
            ph <= ph + 3'd1;
            sh <= (wq == 2'd1) ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
          end
        end
        S_TX_CRC: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) st <= S_TX_EB;
        end
        S_TX_EB: begin st <= S_TOK; cnt <= 4'd0; end
        S_TOK: if (cnt != 4'd0 || !dat_in[0]) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd4) st <= S_BUSY;
        end
        S_BUSY: if (dat_in[0]) st <= S_IDLE;
        S_RX_WAIT: if (!dat_in[0]) begin
          st <= S_RX_DAT; ph <= 3'd0; bcnt <= '0;
        end
        S_RX_DAT: begin
          sh <= rx_next;
          if (last_ph) begin
            rd_data <= rx_next; rd_valid <= 1'b1; ph <= 3'd0;
            if (last_byte) begin
              st <= S_RX_CRC; cnt <= 4'd0;
            end else bcnt <= bcnt + 1'b1;
          end else ph <= ph + 3'd1;
        end
        S_RX_CRC: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) st <= S_RX_EB;
        end
        S_RX_EB: begin
          if (|(crc_nz & act)) crc_err <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_lane_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe & ~(act | 8'h04)) == 8'h00);
  assert_ready_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> dat_oe == act);
  assert_end_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TX_EB |=> dat_oe == 8'h00);
  assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && wq != 2'd2 |=> !rd_valid);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !err_clr |=> crc_err);
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    card_busy && dat_in[0] |=> !card_busy);
  assert_rw_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe == 8'h04 && !dat_out[2] |-> $past(rw_en && rw_req));
endmodule

// File: tb/sd_dat_agent_test.sv
`timescale 1ns/1ps
module sd_dat_agent_test;
  localparam int BLEN_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] lane_sel = 2'b00;
  logic [BLEN_W-1:0] blk_len = '0;
  logic wr_start = 0, rd_start = 0, wr_valid = 1, err_clr = 0, rw_en = 0, rw_req = 0;
  logic [7:0] wr_data, rd_data, dat_out, dat_oe;
  logic [7:0] dat_in = 8'hFF;
  logic wr_ready, rd_valid, card_busy, crc_err;

  sd_dat_agent #(.BLEN_W(BLEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .blk_len(blk_len),
    .wr_start(wr_start), .rd_start(rd_start), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .dat_in(dat_in),
    .dat_out(dat_out), .dat_oe(dat_oe), .card_busy(card_busy), .crc_err(crc_err),
    .err_clr(err_clr), .rw_en(rw_en), .rw_req(rw_req));

  always #4 clk = ~clk;

  typedef struct {
    logic busy; logic [7:0] oe; logic [7:0] out; logic rv; logic [7:0] rd; string tag;
  } exp_t;

  exp_t eq[$];
  int vec = 0, bad = 0;
  logic err_exp = 1'b0, idle_m = 1'b1;
  logic [7:0] txbuf [64];
  logic [7:0] blk [64];
  int tx_ptr = 0;

  assign wr_data = txbuf[tx_ptr % 64];
  always @(posedge clk) if (wr_ready && wr_valid) tx_ptr <= tx_ptr + 1;

  function automatic int lanes_of(int sel);
    return (sel == 1) ? 4 : (sel == 2) ? 8 : 1;
  endfunction

  function automatic logic lane_bit(int lanes, int k, int i);
    int cpb = 8 / lanes;
    logic [7:0] b = blk[i / cpb];
    int p = i % cpb;
    if (lanes == 1) return b[7 - p];
    if (lanes == 4) return (p == 0) ? b[k + 4] : b[k];
    return b[k];
  endfunction

  function automatic logic [15:0] lane_crc(int lanes, int k, int nb);
    bit r[$];
    logic [16:0] g = 17'h11021;
    logic [15:0] res;
    int n = nb * 8 / lanes;
    for (int i = 0; i < n; i++) r.push_back(lane_bit(lanes, k, i));
    for (int i = 0; i < 16; i++) r.push_back(1'b0);
    for (int i = 0; i < n; i++)
      if (r[i]) for (int j = 0; j < 17; j++) r[i + j] = r[i + j] ^ g[16 - j];
    for (int i = 0; i < 16; i++) res[15 - i] = r[n + i];
    return res;
  endfunction

  task automatic push(logic b, logic [7:0] oe, logic [7:0] out, logic rv, logic [7:0] rd, string tag);
    exp_t e;
    e.busy = b; e.oe = oe; e.out = out; e.rv = rv; e.rd = rd; e.tag = tag;
    eq.push_back(e);
  endtask

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic tick();
    exp_t e;
    logic rw;
    string t;
    @(negedge clk);
    rw = idle_m && rw_en && rw_req;
    if (eq.size() > 0) e = eq.pop_front();
    else begin
      e.busy = 0; e.oe = rw ? 8'h04 : 8'h00; e.out = rw ? 8'hFB : 8'hFF;
      e.rv = 0; e.rd = 0; e.tag = rw ? "R10" : "R1";
    end
    vec++;
    if (card_busy !== e.busy || dat_oe !== e.oe || dat_out !== e.out || rd_valid !== e.rv ||
        (e.rv && rd_data !== e.rd) || crc_err !== err_exp) begin
      bad++;
      t = (crc_err !== err_exp) ? "R8" : e.tag;
      $display("FAIL %s vector %0d: got busy=%b oe=%h out=%h rv=%b rd=%h err=%b expected busy=%b oe=%h out=%h rv=%b rd=%h err=%b",
               t, vec, card_busy, dat_oe, dat_out, rd_valid, rd_data, crc_err,
               e.busy, e.oe, e.out, e.rv, e.rd, err_exp);
    end
  endtask

  // R9: status token then busy on lane 0
  task automatic card_reply(int gap, int blen);
    bit bits[$];
    int endi;
    for (int i = 0; i < gap; i++) bits.push_back(1);
    bits.push_back(0); bits.push_back(0); bits.push_back(1); bits.push_back(0);
    endi = bits.size();
    bits.push_back(1);
    for (int i = 0; i < blen; i++) bits.push_back(0);
    bits.push_back(1);
    for (int i = 0; i < bits.size(); i++) begin
      dat_in = {7'h7F, bits[i]};
      push((i >= endi && i < bits.size() - 1) ? 1'b1 : 1'b0, 8'h00, 8'hFF, 0, 0, "R9");
      tick();
    end
    dat_in = 8'hFF;
  endtask

  task automatic do_write(int sel, int nb, int seed, int blen, bit poke);
    int lanes = lanes_of(sel);
    int n = nb * 8 / lanes;
    logic [7:0] act = (lanes == 8) ? 8'hFF : (lanes == 4) ? 8'h0F : 8'h01;
    logic [15:0] c [8];
    logic [7:0] v;
    int p0;
    for (int i = 0; i < nb; i++) begin
      blk[i] = 8'((seed * 37 + i * 91 + 5) & 255);
      txbuf[(tx_ptr + i) % 64] = blk[i];
    end
    for (int k = 0; k < lanes; k++) c[k] = lane_crc(lanes, k, nb);
    push(0, act, ~act, 0, 0, (sel == 3) ? "R2" : "R3");
    for (int i = 0; i < n; i++) begin
      v = 8'hFF;
      for (int k = 0; k < lanes; k++) v[k] = lane_bit(lanes, k, i);
      push(0, act, v, 0, 0, "R4");
    end
    for (int i = 0; i < 16; i++) begin
      v = 8'hFF;
      for (int k = 0; k < lanes; k++) v[k] = c[k][15 - i];
      push(0, act, v, 0, 0, "R5");
    end
    push(0, act, 8'hFF, 0, 0, "R3");
    p0 = tx_ptr;
    lane_sel = 2'(sel); blk_len = BLEN_W'(nb); wr_start = 1; idle_m = 0;
    tick();
    wr_start = 0;
    for (int i = 1; i < n + 18; i++) begin
      if (poke && i == 3) rd_start = 1;  // R11
      tick();
      rd_start = 0;
    end
    chk(tx_ptr - p0 == nb, "R6", "bytes taken", tx_ptr - p0, nb);
    card_reply(2, blen);
    tick();
    idle_m = 1;
  endtask

  task automatic do_read(int sel, int nb, int seed, int corrupt, bit garbage, bit rwmid, bit poke);
    int lanes = lanes_of(sel);
    int cpb = 8 / lanes;
    int n = nb * 8 / lanes;
    logic [7:0] act = (lanes == 8) ? 8'hFF : (lanes == 4) ? 8'h0F : 8'h01;
    logic [15:0] c [8];
    logic [7:0] v, g;
    for (int i = 0; i < nb; i++) blk[i] = 8'((seed * 53 + i * 113 + 17) & 255);
    for (int k = 0; k < 8; k++) c[k] = (k < lanes) ? lane_crc(lanes, k, nb) : 16'h0;
    if (corrupt >= 0) c[corrupt][3] = ~c[corrupt][3];
    lane_sel = 2'(sel); blk_len = BLEN_W'(nb); rd_start = 1; idle_m = 0; dat_in = 8'hFF;
    tick();
    rd_start = 0;
    tick(); tick();
    g = garbage ? 8'hA6 : 8'hFF;
    dat_in = (g & ~act);
    tick();
    for (int i = 0; i < n; i++) begin
      v = 8'hFF;
      for (int k = 0; k < lanes; k++) v[k] = lane_bit(lanes, k, i);
      g = garbage ? 8'((i * 29 + 3) & 255) : 8'hFF;
      dat_in = (g & ~act) | (v & act);
      if (i % cpb == cpb - 1) push(0, 8'h00, 8'hFF, 1, blk[i / cpb], "R7");
      if (rwmid && i == 1) begin rw_en = 1; rw_req = 1; end  // R10: ignored in block
      if (poke && i == 1) wr_start = 1;                       // R11
      tick();
      wr_start = 0;
    end
    for (int i = 0; i < 16; i++) begin
      v = 8'hFF;
      for (int k = 0; k < lanes; k++) v[k] = c[k][15 - i];
      g = garbage ? 8'((i * 71 + 9) & 255) : 8'hFF;
      dat_in = (g & ~act) | (v & act);
      tick();
    end
    dat_in = garbage ? 8'h3F : 8'hFF;
    if (corrupt >= 0 && corrupt < lanes) err_exp = 1;
    tick();
    dat_in = 8'hFF; rw_req = 0; rw_en = 0;
    tick();
    idle_m = 1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL R1 watchdog expired: got hang expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) txbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    tick();
    chk(wr_ready == 1'b0, "R1", "wr_ready after reset", int'(wr_ready), 0);
    tick();
    do_write(0, 2, 1, 5, 0);
    do_write(1, 3, 2, 0, 0);
    do_write(2, 4, 3, 3, 1);
    do_write(3, 1, 4, 1, 0);
    do_read(0, 2, 5, -1, 0, 0, 0);
    do_read(1, 3, 6, 2, 0, 0, 0);
    // R8: clear the sticky flag
    err_clr = 1; err_exp = 0;
    tick();
    err_clr = 0;
    tick();
    do_read(2, 4, 7, -1, 0, 1, 1);
    do_read(0, 2, 8, -1, 1, 0, 0);
    do_read(2, 2, 9, 6, 0, 0, 0);
    tick();
    err_clr = 1; err_exp = 0;
    tick();
    err_clr = 0;
    // R10: read-wait in idle, then disabled
    rw_en = 1; rw_req = 1;
    tick(); tick();
    rw_req = 0;
    tick();
    rw_en = 0; rw_req = 1;
    tick(); tick();
    rw_req = 0;
    tick();
    do_write(1, 2, 10, 2, 0);
    tick();
    finish_run();
  end
endmodule